// File: doc/BRIEF.md
# Pin Driver Command Processor

This block controls a bank of 56 general-purpose pins: 40 socket pins followed by 16 connector positions. It takes a stream of fixed 8-byte command packets, one byte per accepted cycle. For every pin it holds four pieces of state: an output-enable, an output level, a pull mode (none, up or down) and a supply-assignment flag. Five opcodes act on this state. One clears everything. Two apply a global pull-up or a global pull-down. One drives a single pin. One reads back the levels of all pins.

The supply flags come from the neighbouring supply-mapping logic through a mark strobe. A pin that carries a supply flag never enables its output driver. The pull and drive commands also leave such a pin alone.

Three connector positions, J12, J14 and J16, have no physical I/O behind them. They are built as permanently inert pins.

A read command captures the pin levels at once. It then streams a 16-byte reply, one byte per cycle. While the reply is streaming, the packet input is stalled.

Top module: `pincmd_top`

## Requirements
- R1: After synchronous reset all pins are inputs with output level 0, no pull and no supply flag. `in_ready` is 1 and `out_valid` is 0.
- R2: Opcode 0x2D makes every pin an input with output level 0, clears all supply flags and removes all pulls.
- R3: Opcode 0x31 makes every pin that has no supply flag an input with pull-up. A pin with a supply flag keeps all of its state.
- R4: Opcode 0x32 does the same as R3 with pull-down. `pin_pu` and `pin_pd` are never both set for one pin.
- R5: Opcode 0x36 takes the level in byte 1 and the pin index in byte 4. Index 0..39 selects state bit 0..39 (socket pins 1..40). Index 40..55 selects bit 40..55 (connector J1..J16). The selected pin becomes an output driving that level, and its pull mode is not changed.
- R6: Bits 51, 53 and 55 (J12, J14, J16) never show an output-enable, a pull or a supply flag. A drive command aimed at them changes nothing.
- R7: A drive command with an index above 55, or with a level byte other than 0 or 1, leaves all state unchanged.
- R8: A supply mark sets the flag of each marked pin and clears its output-enable. Opcodes 0x31, 0x32 and 0x36 do not change a flagged pin. If a mark and opcode 0x2D arrive in the same cycle, the clear wins.
- R9: Opcode 0x35 produces 16 reply bytes. Byte 0 is 0x35 and bytes 1..7 are 0. Bytes 8..14 hold the pin levels captured on the cycle the command completed, with bit 0 of byte 8 being pin bit 0 and bit 0 of byte 13 being J1. Byte 15 is 0. Bits 51, 53 and 55 read as 0.
- R10: `in_ready` is 0 on every cycle that `out_valid` is 1. No input byte is taken during that time.
- R11: An unknown opcode changes no state and produces no reply. The next 8 bytes are parsed as a fresh packet.
- R12: State updates take effect in the cycle after the edge that accepts the 8th byte. The first reply byte appears in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command byte present |
| in_byte | input | 8 | Command byte |
| in_ready | output | 1 | Byte is taken when in_valid and in_ready are both 1 |
| out_valid | output | 1 | Reply byte present |
| out_byte | output | 8 | Reply byte |
| pin_level | input | 56 | Sampled pad levels |
| supply_mark_en | input | 1 | Strobe that applies supply_mark |
| supply_mark | input | 56 | Pins to flag as supply-assigned |
| pin_oe | output | 56 | Output enable per pin |
| pin_out | output | 56 | Output level per pin |
| pin_pu | output | 56 | Pull-up enable per pin |
| pin_pd | output | 56 | Pull-down enable per pin |
| pin_supply | output | 56 | Supply-assignment flag per pin |

## Verification
The bench drives a drive command at a phantom connector position, and at indices and levels just outside the legal range. A design that mapped the phantom positions or checked the range loosely would show a stray output-enable there.

It flags pins as supply, including one that is already driving. It then applies both global pulls and a drive command to those pins. A design that ignored the flag would turn those pins into pulled inputs or re-enable their drivers.

It sends an opcode that no command uses, with non-zero filler, followed directly by a legal packet. A design that lost packet alignment would misread that second packet.

It also reads the pins with a distinct level in every byte. A wrong byte order, a missing phantom mask, or a snapshot taken on the wrong cycle would all be visible in the reply.

// File: rtl/pincmd_pkg.sv
package pincmd_pkg;

    localparam int SOCK_PINS      = 40;
    localparam int CONN_PINS      = 16;
    localparam int PIN_CNT        = SOCK_PINS + CONN_PINS;
    localparam int PIN_W          = $clog2(PIN_CNT);
    localparam int PKT_LEN        = 8;
    localparam int PKT_W          = $clog2(PKT_LEN);
    localparam int RPL_LEN        = 16;
    localparam int RPL_W          = $clog2(RPL_LEN);
    localparam int RPL_DATA_OFS   = 8;
    localparam int RPL_DATA_BYTES = (PIN_CNT + 7) / 8;
    localparam int IDX_LEVEL_BYTE = 1;
    localparam int IDX_PIN_BYTE   = 4;

    localparam logic [7:0] OP_CLEAR  = 8'h2D;
    localparam logic [7:0] OP_PULLUP = 8'h31;
    localparam logic [7:0] OP_PULLDN = 8'h32;
    localparam logic [7:0] OP_READ   = 8'h35;
    localparam logic [7:0] OP_DRIVE  = 8'h36;

    typedef enum logic [2:0] {
        K_NONE, K_CLEAR, K_PULLUP, K_PULLDN, K_DRIVE, K_READ
    } cmd_kind_t;

    typedef enum logic [1:0] {PULL_OFF, PULL_UP, PULL_DN} pull_t;

    typedef struct packed {
        cmd_kind_t        kind;
        logic [PIN_W-1:0] pin;
        logic             level;
    } cmd_t;

    typedef logic [PKT_LEN-1:0][7:0] pkt_t;

    // Connector positions 12, 14 and 16 have no I/O behind them.
    function automatic logic is_phantom(int idx);
        return (idx == SOCK_PINS + 11) || (idx == SOCK_PINS + 13) ||
               (idx == SOCK_PINS + 15);
    endfunction

    function automatic logic [PIN_CNT-1:0] phantom_mask();
        logic [PIN_CNT-1:0] m;
        for (int i = 0; i < PIN_CNT; i++) m[i] = is_phantom(i);
        return m;
    endfunction

    function automatic cmd_t decode(pkt_t p);
        cmd_t c;
        c.kind  = K_NONE;
        c.pin   = p[IDX_PIN_BYTE][PIN_W-1:0];
        c.level = p[IDX_LEVEL_BYTE][0];
        case (p[0])
            OP_CLEAR:  c.kind = K_CLEAR;
            OP_PULLUP: c.kind = K_PULLUP;
            OP_PULLDN: c.kind = K_PULLDN;
            OP_READ:   c.kind = K_READ;
            OP_DRIVE:
                if (p[IDX_PIN_BYTE] < 8'(PIN_CNT) && p[IDX_LEVEL_BYTE] < 8'd2)
                    c.kind = K_DRIVE;
            default:   c.kind = K_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pincmd_parser.sv
module pincmd_parser
    import pincmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [7:0] in_byte,
    output logic       cmd_valid,
    output cmd_t       cmd
);

    logic [PKT_W-1:0] cnt;
    pkt_t             held;
    pkt_t             full;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            held <= '0;
        end else if (take) begin
            held[cnt] <= in_byte;
            cnt       <= cnt + 1'b1;
        end
    end

    always_comb begin
        full            = held;
        full[PKT_LEN-1] = in_byte;
    end

    assign cmd_valid = take && (cnt == PKT_W'(PKT_LEN - 1));
    assign cmd       = decode(full);

    // R11: a completed packet always leaves the parser at a packet boundary
    a_r11_boundary: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> cnt == '0);

endmodule

// File: rtl/pincmd_bank.sv
module pincmd_bank
    import pincmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  cmd_t               cmd,
    input  logic               mark_en,
    input  logic [PIN_CNT-1:0] mark,
    output logic [PIN_CNT-1:0] oe,
    output logic [PIN_CNT-1:0] outv,
    output logic [PIN_CNT-1:0] pu,
    output logic [PIN_CNT-1:0] pd,
    output logic [PIN_CNT-1:0] sup
);

    localparam logic [PIN_CNT-1:0] PHANTOM = phantom_mask();

    logic do_clear;
    assign do_clear = cmd_valid && cmd.kind == K_CLEAR;

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
        if (is_phantom(i)) begin : g_inert
            assign oe[i]   = 1'b0;
            assign outv[i] = 1'b0;
            assign pu[i]   = 1'b0;
            assign pd[i]   = 1'b0;
            assign sup[i]  = 1'b0;
        end else begin : g_live
            logic  oe_q, out_q, sup_q;
            pull_t pull_q;

            always_ff @(posedge clk) begin
                if (rst || do_clear) begin
                    oe_q   <= 1'b0;
                    out_q  <= 1'b0;
                    sup_q  <= 1'b0;
                    pull_q <= PULL_OFF;
                end else begin
                    if (cmd_valid && !sup_q) begin
                        case (cmd.kind)
                            K_PULLUP: begin oe_q <= 1'b0; pull_q <= PULL_UP; end
                            K_PULLDN: begin oe_q <= 1'b0; pull_q <= PULL_DN; end
                            K_DRIVE:
                                if (cmd.pin == PIN_W'(i)) begin
                                    oe_q  <= 1'b1;
                                    out_q <= cmd.level;
                                end
                            default: ;
                        endcase
                    end
                    if (mark_en && mark[i]) begin
                        sup_q <= 1'b1;
                        oe_q  <= 1'b0;
                    end
                end
            end

            assign oe[i]   = oe_q;
            assign outv[i] = out_q;
            assign pu[i]   = pull_q == PULL_UP;
            assign pd[i]   = pull_q == PULL_DN;
            assign sup[i]  = sup_q;
        end
    end

    a_r2_clear_all: assert property (@(posedge clk) disable iff (rst)
        do_clear |=> (oe | outv | pu | pd | sup) == '0);

    a_r4_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
        (pu & pd) == '0);

    a_r8_supply_no_drive: assert property (@(posedge clk) disable iff (rst)
        (oe & sup) == '0);

    a_r5_drive_taken: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_DRIVE && !sup[cmd.pin] && !PHANTOM[cmd.pin]
         && !(mark_en && mark[cmd.pin]))
        |=> oe[$past(cmd.pin)] && outv[$past(cmd.pin)] == $past(cmd.level));

    a_r3_supply_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_PULLUP) |=> ((pu | sup) & ~PHANTOM) == ~PHANTOM);

endmodule

// File: rtl/pincmd_reply.sv
module pincmd_reply
    import pincmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PIN_CNT-1:0] level,
    output logic               busy,
    output logic [7:0]         rbyte
);

    localparam logic [PIN_CNT-1:0] PHANTOM = phantom_mask();
    localparam int               SNAP_W  = RPL_DATA_BYTES * 8;

    logic [SNAP_W-1:0] snap;
    logic [RPL_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            snap <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            idx  <= '0;
            snap <= SNAP_W'(level & ~PHANTOM);
        end else if (busy) begin
            if (idx == RPL_W'(RPL_LEN - 1)) busy <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        rbyte = 8'h00;
        if (idx == '0) rbyte = OP_READ;
        for (int k = 0; k < RPL_DATA_BYTES; k++)
            if (idx == RPL_W'(RPL_DATA_OFS + k)) rbyte = snap[k*8 +: 8];
    end

    a_r9_header: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> rbyte == OP_READ);

    a_r9_reply_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(idx) == RPL_W'(RPL_LEN - 1));

    a_r6_phantom_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == RPL_W'(RPL_DATA_OFS + RPL_DATA_BYTES - 1))
        |-> (rbyte & PHANTOM[PIN_CNT-1 -: 8]) == 8'h00);

endmodule

// File: rtl/pincmd_top.sv
module pincmd_top
    import pincmd_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [7:0]                 in_byte,
    output logic                       in_ready,
    output logic                       out_valid,
    output logic [7:0]                 out_byte,
    input  logic [PIN_CNT-1:0]         pin_level,
    input  logic                       supply_mark_en,
    input  logic [PIN_CNT-1:0]         supply_mark,
    output logic [PIN_CNT-1:0]         pin_oe,
    output logic [PIN_CNT-1:0]         pin_out,
    output logic [PIN_CNT-1:0]         pin_pu,
    output logic [PIN_CNT-1:0]         pin_pd,
    output logic [PIN_CNT-1:0]         pin_supply
);

    logic take, cmd_valid, busy;
    cmd_t cmd;

    assign in_ready  = !busy;
    assign take      = in_valid && in_ready;
    assign out_valid = busy;

    pincmd_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .in_byte   (in_byte),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    pincmd_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .mark_en   (supply_mark_en),
        .mark      (supply_mark),
        .oe        (pin_oe),
        .outv      (pin_out),
        .pu        (pin_pu),
        .pd        (pin_pd),
        .sup       (pin_supply)
    );

    pincmd_reply u_reply (
        .clk   (clk),
        .rst   (rst),
        .start (cmd_valid && cmd.kind == K_READ),
        .level (pin_level),
        .busy  (busy),
        .rbyte (out_byte)
    );

    // R11: a dropped packet touches neither pins nor the reply path
    a_r11_unknown_silent: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_NONE && !supply_mark_en)
        |=> !out_valid && $stable(pin_oe) && $stable(pin_pu) && $stable(pin_pd)
            && $stable(pin_out) && $stable(pin_supply));

    // R12: reply starts on the cycle right after a read completes
    a_r12_reply_start: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.kind == K_READ) |=> out_valid && out_byte == OP_READ);

endmodule

// File: tb/sim_pincmd_top.sv
module sim_pincmd_top;
    import pincmd_pkg::*;

    localparam int CLK_PER = 10;
    localparam int N = PIN_CNT;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [7:0]   in_byte = 8'h00;
    logic         in_ready, out_valid;
    logic [7:0]   out_byte;
    logic [N-1:0] pin_level = '0;
    logic         supply_mark_en = 1'b0;
    logic [N-1:0] supply_mark = '0;
    logic [N-1:0] pin_oe, pin_out, pin_pu, pin_pd, pin_supply;

    int total = 0;
    int bad   = 0;

    always #(CLK_PER/2) clk = ~clk;

    pincmd_top u0 (.*);

    // behavioural reference model
    logic [N-1:0] m_oe, m_out, m_pu, m_pd, m_sup;
    logic [7:0]   m_pkt[$];
    logic [7:0]   m_rq[$];
    logic [N-1:0] ghost;

    initial begin
        ghost = '0;
        ghost[51] = 1'b1; ghost[53] = 1'b1; ghost[55] = 1'b1;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_oe = '0; m_out = '0; m_pu = '0; m_pd = '0; m_sup = '0;
            m_pkt.delete(); m_rq.delete();
        end else begin
            automatic bit rdy = (m_rq.size() == 0);
            automatic bit cleared = 0;
            if (!rdy) void'(m_rq.pop_front());
            if (in_valid && rdy) begin
                m_pkt.push_back(in_byte);
                if (m_pkt.size() == 8) begin
                    case (m_pkt[0])
                        8'h2D: begin
                            m_oe = '0; m_out = '0; m_pu = '0; m_pd = '0; m_sup = '0;
                            cleared = 1;
                        end
                        8'h31, 8'h32:
                            for (int i = 0; i < N; i++)
                                if (!m_sup[i] && !ghost[i]) begin
                                    m_oe[i] = 0;
                                    m_pu[i] = (m_pkt[0] == 8'h31);
                                    m_pd[i] = (m_pkt[0] == 8'h32);
                                end
                        8'h36: begin
                            automatic int p = m_pkt[4];
                            if (p < N && m_pkt[1] <= 1 && !ghost[p] && !m_sup[p]) begin
                                m_oe[p]  = 1;
                                m_out[p] = m_pkt[1][0];
                            end
                        end
                        8'h35: begin
                            automatic logic [N-1:0] s = pin_level & ~ghost;
                            m_rq.push_back(8'h35);
                            for (int k = 1; k < 8; k++) m_rq.push_back(8'h00);
                            for (int k = 0; k < 7; k++) m_rq.push_back(s[k*8 +: 8]);
                            m_rq.push_back(8'h00);
                        end
                        default: ;
                    endcase
                    m_pkt.delete();
                end
            end
            if (supply_mark_en && !cleared)
                for (int i = 0; i < N; i++)
                    if (supply_mark[i] && !ghost[i]) begin
                        m_sup[i] = 1; m_oe[i] = 0;
                    end
        end
    end

    // R12: every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            automatic bit mv = (m_rq.size() != 0);
            total++;
            if (pin_oe !== m_oe || pin_out !== m_out || pin_pu !== m_pu ||
                pin_pd !== m_pd || pin_supply !== m_sup || in_ready !== !mv ||
                out_valid !== mv || (mv && out_byte !== m_rq[0])) begin
                bad++;
                $display("FAIL R12 cycle compare: oe=%h/%h pu=%h/%h pd=%h/%h sup=%h/%h rdy=%b/%b ov=%b/%b byte=%h/%h",
                         pin_oe, m_oe, pin_pu, m_pu, pin_pd, m_pd, pin_supply, m_sup,
                         in_ready, !mv, out_valid, mv, out_byte, mv ? m_rq[0] : 8'h00);
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        while (m_rq.size() != 0) @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_pkt(input logic [7:0] op, input logic [7:0] lvl,
                            input logic [7:0] idx, input logic [7:0] fill);
        send_byte(op); send_byte(lvl); send_byte(fill); send_byte(fill);
        send_byte(idx); send_byte(fill); send_byte(fill); send_byte(fill);
        @(negedge clk);
    endtask

    task automatic mark(input logic [N-1:0] m);
        @(negedge clk);
        supply_mark_en = 1'b1;
        supply_mark    = m;
        @(posedge clk);
        #1 supply_mark_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [N-1:0] nonghost;
        logic [N-1:0] lv;
        logic [7:0]   got[$];
        nonghost = ~ghost;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", 64'(pin_oe | pin_out | pin_pu | pin_pd | pin_supply), 64'h0);
        chk("R1 ready", {in_ready, out_valid}, 64'b10);

        // R5 drive socket and connector pins
        send_pkt(8'h36, 8'h01, 8'd3, 8'h00);
        chk("R5 socket pin3", {pin_oe[3], pin_out[3]}, 64'b11);
        send_pkt(8'h36, 8'h00, 8'd45, 8'h00);
        chk("R5 J6 bit45", {pin_oe[45], pin_out[45]}, 64'b10);
        send_pkt(8'h36, 8'h01, 8'd39, 8'h00);
        chk("R5 pin39", {pin_oe[39], pin_out[39]}, 64'b11);

        // R6 phantom position J12
        send_pkt(8'h36, 8'h01, 8'd51, 8'h00);
        chk("R6 phantom drive", {pin_oe[51], pin_out[51]}, 64'b00);

        // R7 out-of-range index and bad level
        send_pkt(8'h36, 8'h01, 8'd56, 8'h00);
        send_pkt(8'h36, 8'h02, 8'd7, 8'h00);
        chk("R7 ignored", 64'(pin_oe), 64'((56'd1 << 3) | (56'd1 << 45) | (56'd1 << 39)));

        // R8 supply mark on a driving pin and on pin 0
        mark(56'd1 | (56'd1 << 3));
        chk("R8 mark", {pin_supply[0], pin_supply[3], pin_oe[3]}, 64'b110);

        // R3 pull-up skips supply pins
        send_pkt(8'h31, 8'h00, 8'h00, 8'h00);
        chk("R3 pullup", 64'(pin_pu), 64'(nonghost & ~56'h9));
        chk("R3 inputs", 64'(pin_oe), 64'h0);
        chk("R6 phantom pull", {pin_pu[51], pin_pu[53], pin_pu[55]}, 64'b000);

        // R4 pull-down
        send_pkt(8'h32, 8'h00, 8'h00, 8'h00);
        chk("R4 pulldown", 64'(pin_pd), 64'(nonghost & ~56'h9));
        chk("R4 no pullup left", 64'(pin_pu), 64'h0);

        // R8 drive to supply pin ignored
        send_pkt(8'h36, 8'h01, 8'd3, 8'h00);
        chk("R8 drive supply", {pin_oe[3], pin_supply[3]}, 64'b01);

        // R11 unknown opcode, then aligned packet
        send_pkt(8'h77, 8'h36, 8'h36, 8'h36);
        chk("R11 no reply", {out_valid, in_ready}, 64'b01);
        send_pkt(8'h36, 8'h01, 8'd20, 8'h00);
        chk("R11 resync", {pin_oe[20], pin_out[20]}, 64'b11);

        // R9 / R10 read back
        lv = {8'hFF, 8'h3C, 8'h5A, 8'hC3, 8'h96, 8'h0F, 8'hF1};
        pin_level = lv;
        send_pkt(8'h35, 8'h00, 8'h00, 8'h00);
        pin_level = ~lv;
        got.delete();
        while (out_valid) begin
            got.push_back(out_byte);
            chk("R10 stall", 64'(in_ready), 64'h0);
            @(negedge clk);
        end
        chk("R9 length", 64'(got.size()), 64'd16);
        if (got.size() == 16) begin
            chk("R9 header", 64'(got[0]), 64'h35);
            chk("R9 byte8", 64'(got[8]), 64'hF1);
            chk("R9 J1 byte13", 64'(got[13]), 64'h3C);
            chk("R9 phantom byte14", 64'(got[14]), 64'h57);
            chk("R9 tail", 64'(got[15] | got[1] | got[7]), 64'h0);
        end

        // R2 clear, with a simultaneous mark that must lose
        send_byte(8'h2D);
        for (int k = 0; k < 6; k++) send_byte(8'h00);
        @(negedge clk);
        in_valid = 1'b1; in_byte = 8'h00;
        supply_mark_en = 1'b1; supply_mark = 56'hF0;
        @(posedge clk);
        #1 in_valid = 1'b0; supply_mark_en = 1'b0;
        @(negedge clk);
        chk("R2 clear", 64'(pin_oe | pin_out | pin_pu | pin_pd | pin_supply), 64'h0);
        chk("R8 clear wins", 64'(pin_supply), 64'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule